// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block turns the operand fields of a small 8-bit core into a 12-bit byte address and serves the matching data memory. The address comes from one of three sources. In banked mode a four-bit bank number is joined to an 8-bit offset. In window mode a fixed window is used, made of the lowest half of bank 0 and the highest half of bank 15, and the bank number plays no part. In pointer mode a full 12-bit pointer reaches any byte without banking. Reads are combinational from the formed address. Writes happen at the rising clock edge.

Two regions of the space hold storage. The general-purpose region starts at 0x000 and grows upward. The special-function region ends at 0xFFF and grows downward, and it never reaches below 0xF80. Any address outside both regions reads as zero and ignores writes. A register-to-register move copies one byte between any two 12-bit addresses in two cycles. Storage is never cleared by reset; only the bank register and the move sequencer are reset.

Top module: `bank_mem_unit`

## Requirements
- R1: With `ptrSel` and `winSel` both low, `effAddr` equals {bank[3:0], `opAddr`}.
- R2: A `bankWrEn` pulse stores `bankWrData[3:0]` at the clock edge. `bankQ[7:4]` always reads 0. Reset sets `bankQ` to 0x00.
- R3: With `winSel` high and `ptrSel` low, `effAddr` is 0x000+`opAddr` when `opAddr[7]`=0 and 0xF00+`opAddr` when `opAddr[7]`=1, whatever the bank holds.
- R4: With `ptrSel` high, `effAddr` equals `ptr`. This ignores both `winSel` and the bank.
- R5: Addresses below `GPR_BYTES`, and addresses from 0x1000-`SFR_COUNT` up to 0xFFF, hold storage. `wrEn` stores `wrData` at `effAddr` on the clock edge, and `rdData` shows the byte at `effAddr` in the same cycle.
- R6: Every other address reads 0x00, and a write to it has no effect.
- R7: A `moveStart` pulse while idle captures `moveSrc` and `moveDst`. `moveBusy` is high for exactly the next cycle. The source byte is captured at the end of that cycle, and the destination is written at the end of the cycle after it.
- R8: `moveStart` and changes to `moveSrc` and `moveDst` during a move are ignored. A `wrEn` during the second move cycle is dropped.
- R9: Reset leaves the storage contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opAddr | input | 8 | Direct operand offset |
| winSel | input | 1 | Selects window mode |
| ptrSel | input | 1 | Selects pointer mode (priority) |
| ptr | input | 12 | Full pointer address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Byte at effAddr |
| effAddr | output | 12 | Formed address |
| bankWrEn | input | 1 | Bank register write strobe |
| bankWrData | input | 8 | Bank register write value |
| bankQ | output | 8 | Bank register read value |
| moveStart | input | 1 | Starts a two-cycle move |
| moveSrc | input | 12 | Move source address |
| moveDst | input | 12 | Move destination address |
| moveBusy | output | 1 | High in the first move cycle |

## Verification
Some properties are checked on every cycle by the assertions: the window mode only ever produces bank 0 or bank 15, every read outside the regions returns zero, a bank write shows up masked on the next cycle, the busy flag lasts one cycle, and a finished move leaves the captured byte at the destination. Other behaviour needs the bench's scenarios, because no single-cycle property can cover it. These are that the stored contents survive reset, that a held start or a changed source does not disturb a move in progress, that a write in the second move cycle is dropped, and that random mixed traffic matches a byte-level model.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int ADDR_W = 12;
  localparam int SPACE  = 1 << ADDR_W;

  typedef enum logic [1:0] {MV_IDLE, MV_LATCH, MV_WRITE} moveState_t;

  typedef struct packed {
    logic captureAddr;
    logic latchSrc;
    logic writeMove;
    logic blockExt;
  } bmuStrobe_t;
endpackage

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       moveStart,
  output bmuStrobe_t strb,
  output logic       moveBusy
);
  moveState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) state <= MV_IDLE;
    else begin
      case (state)
        MV_IDLE:  if (moveStart) state <= MV_LATCH;
        MV_LATCH: state <= MV_WRITE;
        default:  state <= MV_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.captureAddr = (state == MV_IDLE) && moveStart;
    strb.latchSrc    = (state == MV_LATCH);
    strb.writeMove   = (state == MV_WRITE);
    strb.blockExt    = (state == MV_WRITE);
    moveBusy         = (state == MV_LATCH);
  end

  // R7: busy lasts a single cycle and is followed by the write cycle
  p_busy_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    moveBusy |=> !moveBusy && strb.writeMove);
  // R7: an idle start raises busy next cycle
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (moveStart && !moveBusy && !strb.writeMove) |=> moveBusy);
  // R8: a start during the write cycle does not re-arm
  p_no_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeMove |=> !moveBusy);
endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int GPR_BYTES = 512,
  parameter int SFR_COUNT = 96
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  opAddr,
  input  logic        winSel,
  input  logic        ptrSel,
  input  logic [11:0] ptr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        bankWrEn,
  input  logic [7:0]  bankWrData,
  input  logic [11:0] moveSrc,
  input  logic [11:0] moveDst,
  input  bmuStrobe_t  strb,
  output logic [11:0] effAddr,
  output logic [7:0]  rdData,
  output logic [7:0]  bankQ
);
  localparam int SFR_BASE  = SPACE - SFR_COUNT;
  localparam int GPR_IDX_W = $clog2(GPR_BYTES);
  localparam int SFR_IDX_W = $clog2(SFR_COUNT);

  logic [7:0]  gprMem [GPR_BYTES];
  logic [7:0]  sfrMem [SFR_COUNT];
  logic [7:0]  bankReg;
  logic [11:0] srcReg, dstReg;
  logic [7:0]  srcData;
  logic [7:0]  srcView, dstView;
  logic [11:0] wrAddr;
  logic [7:0]  wrVal;
  logic        doWr;

  function automatic logic inGpr(input logic [11:0] a);
    return a < 12'(GPR_BYTES);
  endfunction

  function automatic logic inSfr(input logic [11:0] a);
    return a >= 12'(SFR_BASE);
  endfunction

  function automatic logic [SFR_IDX_W-1:0] sfrIdx(input logic [11:0] a);
    logic [11:0] off;
    off = a - 12'(SFR_BASE);
    return off[SFR_IDX_W-1:0];
  endfunction

  function automatic logic [7:0] readAt(input logic [11:0] a);
    if (inGpr(a))      return gprMem[a[GPR_IDX_W-1:0]];
    else if (inSfr(a)) return sfrMem[sfrIdx(a)];
    else               return 8'h00;
  endfunction

  // address formation: pointer > window > banked
  always_comb begin
    if (ptrSel)      effAddr = ptr;
    else if (winSel) effAddr = {{4{opAddr[7]}}, opAddr};
    else             effAddr = {bankReg[3:0], opAddr};
  end

  assign rdData  = readAt(effAddr);
  assign srcView = readAt(srcReg);
  assign dstView = readAt(dstReg);
  assign bankQ   = bankReg;

  always_ff @(posedge clk) begin
    if (!rstN) bankReg <= 8'h00;
    else if (bankWrEn) bankReg <= bankWrData & 8'h0F;
  end

  always_ff @(posedge clk) begin
    if (strb.captureAddr) begin
      srcReg <= moveSrc;
      dstReg <= moveDst;
    end
    if (strb.latchSrc) srcData <= srcView;
  end

  always_comb begin
    doWr   = strb.writeMove || (wrEn && !strb.blockExt);
    wrAddr = strb.writeMove ? dstReg  : effAddr;
    wrVal  = strb.writeMove ? srcData : wrData;
  end

  // storage is deliberately left out of reset
  generate
    if (SFR_COUNT > 0) begin : g_sfr
      always_ff @(posedge clk)
        if (doWr && inSfr(wrAddr)) sfrMem[sfrIdx(wrAddr)] <= wrVal;
    end
  endgenerate

  always_ff @(posedge clk)
    if (doWr && inGpr(wrAddr)) gprMem[wrAddr[GPR_IDX_W-1:0]] <= wrVal;

  // R2: bank write lands masked
  p_bank_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    bankWrEn |=> bankQ == {4'h0, $past(bankWrData[3:0])});
  // R3: window mode only touches bank 0 or bank 15
  p_window_banks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (winSel && !ptrSel) |-> ((effAddr[11:8] == 4'h0) || (effAddr[11:8] == 4'hF))
                            && effAddr[7:0] == opAddr);
  // R4: pointer mode passes the pointer through
  p_ptr_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    ptrSel |-> effAddr == ptr);
  // R6: holes read zero
  p_hole_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(inGpr(effAddr) || inSfr(effAddr)) |-> rdData == 8'h00);
  // R7: move result appears at destination
  p_move_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeMove && (inGpr(dstReg) || inSfr(dstReg))) |=> dstView == $past(srcData));
endmodule

// File: rtl/bank_mem_unit.sv
module bank_mem_unit
  import bmu_pkg::*;
#(
  parameter int GPR_BYTES = 512,
  parameter int SFR_COUNT = 96
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  opAddr,
  input  logic        winSel,
  input  logic        ptrSel,
  input  logic [11:0] ptr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic [11:0] effAddr,
  input  logic        bankWrEn,
  input  logic [7:0]  bankWrData,
  output logic [7:0]  bankQ,
  input  logic        moveStart,
  input  logic [11:0] moveSrc,
  input  logic [11:0] moveDst,
  output logic        moveBusy
);
  bmuStrobe_t strb;

  bmu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .moveStart(moveStart),
    .strb(strb), .moveBusy(moveBusy)
  );

  bmu_datapath #(.GPR_BYTES(GPR_BYTES), .SFR_COUNT(SFR_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .opAddr(opAddr), .winSel(winSel), .ptrSel(ptrSel),
    .ptr(ptr), .wrEn(wrEn), .wrData(wrData), .bankWrEn(bankWrEn),
    .bankWrData(bankWrData), .moveSrc(moveSrc), .moveDst(moveDst),
    .strb(strb), .effAddr(effAddr), .rdData(rdData), .bankQ(bankQ)
  );
endmodule

// File: tb/bank_mem_unit_test.sv
`timescale 1ns/1ps
module bank_mem_unit_test;
  localparam int GPR = 512;
  localparam int SFRN = 96;
  localparam int SBASE = 4096 - SFRN;

  logic clk = 0, rstN = 0;
  logic [7:0] opAddr = 0, wrData = 0, bankWrData = 0;
  logic winSel = 0, ptrSel = 0, wrEn = 0, bankWrEn = 0, moveStart = 0;
  logic [11:0] ptr = 0, moveSrc = 0, moveDst = 0;
  logic [7:0] rdData, bankQ;
  logic [11:0] effAddr;
  logic moveBusy;

  int nChk = 0, nBad = 0;
  bit finished = 0;
  logic [7:0] mGpr [GPR];
  logic [7:0] mSfr [SFRN];
  logic [3:0] mBank = 0;

  bank_mem_unit uut (.*);

  always #4 clk = ~clk;

  function automatic logic [11:0] expAddr(logic [7:0] op, logic w, logic p, logic [11:0] pt, logic [3:0] b);
    if (p) return pt;
    if (w) return op[7] ? {4'hF, op} : {4'h0, op};
    return {b, op};
  endfunction

  function automatic bit impl(logic [11:0] a);
    return (a < GPR) || (a >= SBASE);
  endfunction

  function automatic logic [7:0] mRead(logic [11:0] a);
    if (a < GPR) return mGpr[a];
    if (a >= SBASE) return mSfr[a - SBASE];
    return 8'h00;
  endfunction

  task automatic mWrite(logic [11:0] a, logic [7:0] d);
    if (a < GPR) mGpr[a] = d;
    else if (a >= SBASE) mSfr[a - SBASE] = d;
  endtask

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check comb outputs, commit at posedge
  task automatic access(logic [7:0] op, logic w, logic p, logic [11:0] pt, logic we, logic [7:0] wd, string tag);
    logic [11:0] a;
    @(negedge clk);
    opAddr = op; winSel = w; ptrSel = p; ptr = pt; wrEn = we; wrData = wd;
    #1;
    a = expAddr(op, w, p, pt, mBank);
    check({tag, " addr"}, {4'h0, effAddr}, {4'h0, a});
    check({tag, " data"}, {8'h0, rdData}, {8'h0, mRead(a)});
    @(posedge clk);
    if (we) mWrite(a, wd);
    #1 wrEn = 0;
  endtask

  task automatic setBank(logic [7:0] v);
    @(negedge clk); bankWrEn = 1; bankWrData = v;
    @(posedge clk); mBank = v[3:0];
    #1 bankWrEn = 0;
  endtask

  task automatic readPtr(logic [11:0] a, string tag);
    access(8'h00, 0, 1, a, 0, 8'h00, tag);
  endtask

  // move with optional start-hold and an external write in cycle two
  task automatic doMove(logic [11:0] s, logic [11:0] d, bit hold, bit extWr, logic [11:0] xa);
    logic [7:0] sv;
    @(negedge clk);
    moveStart = 1; moveSrc = s; moveDst = d;
    @(posedge clk);
    @(negedge clk);
    sv = mRead(s);
    moveStart = hold;
    if (hold) begin moveSrc = xa; moveDst = xa; end
    #1 check("R7 busy cycle one", {15'h0, moveBusy}, 16'h1);
    @(posedge clk);
    @(negedge clk);
    moveStart = 0;
    if (extWr) begin ptrSel = 1; ptr = xa; wrEn = 1; wrData = 8'h5A; end
    #1 check("R7 busy low cycle two", {15'h0, moveBusy}, 16'h0);
    @(posedge clk);
    #1 wrEn = 0; ptrSel = 0;
    mWrite(d, sv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++; nChk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset bank", {8'h0, bankQ}, 16'h0);
    check("R7 reset idle", {15'h0, moveBusy}, 16'h0);
    @(negedge clk); rstN = 1;

    // fill all storage through pointer mode
    for (int a = 0; a < 4096; a++)
      if (impl(12'(a))) begin
        @(negedge clk); ptrSel = 1; ptr = 12'(a); wrEn = 1; wrData = 8'($urandom);
        @(posedge clk); mWrite(12'(a), wrData);
      end
    @(negedge clk); wrEn = 0; ptrSel = 0;

    // R2 mask
    setBank(8'hA1);
    #1 check("R2 upper bits zero", {8'h0, bankQ}, 16'h0001);
    // R1 banked
    access(8'h34, 0, 0, 0, 1, 8'hC3, "R1 banked write");
    access(8'h34, 0, 0, 0, 0, 0, "R1 banked read");
    setBank(8'h0F);
    access(8'hE0, 0, 0, 0, 0, 0, "R1 bank15");
    // R3 window ignores bank
    setBank(8'h03);
    access(8'h10, 1, 0, 0, 0, 0, "R3 window low");
    access(8'hFF, 1, 0, 0, 1, 8'h77, "R3 window high write");
    readPtr(12'hFFF, "R3 window high landed");
    // R4 pointer beats window
    access(8'h05, 1, 1, 12'h1F0, 0, 0, "R4 pointer priority");
    // R6 holes
    access(8'h00, 0, 1, 12'h800, 1, 8'hEE, "R6 hole write");
    readPtr(12'h800, "R6 hole read");
    readPtr(12'hF80, "R6 sfr gap read");
    readPtr(12'(SBASE - 1), "R6 below sfr");
    readPtr(12'(GPR), "R6 above gpr");
    // R5 boundaries
    access(8'h00, 0, 1, 12'(SBASE), 1, 8'h3C, "R5 sfr base write");
    readPtr(12'(SBASE), "R5 sfr base read");
    access(8'h00, 0, 1, 12'(GPR - 1), 1, 8'h96, "R5 gpr top write");
    readPtr(12'(GPR - 1), "R5 gpr top read");

    // R7 move across banks
    doMove(12'h010, 12'hFC0, 0, 0, 0);
    readPtr(12'hFC0, "R7 move result");
    doMove(12'hFF0, 12'h1AB, 0, 0, 0);
    readPtr(12'h1AB, "R7 move sfr to gpr");
    // R8 held start with new addresses, ext write in cycle two dropped
    doMove(12'h020, 12'h021, 1, 1, 12'h030);
    readPtr(12'h021, "R8 move dst");
    readPtr(12'h030, "R8 dropped write");
    @(negedge clk); #1 check("R8 no restart", {15'h0, moveBusy}, 16'h0);

    // R9 retention across reset
    @(negedge clk); rstN = 0;
    @(posedge clk); #1 check("R9 reset clears bank", {8'h0, bankQ}, 16'h0);
    mBank = 0;
    @(negedge clk); rstN = 1;
    readPtr(12'h021, "R9 gpr kept");
    readPtr(12'hFFF, "R9 sfr kept");

    // R5 random mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [3:0] mode;
      mode = 4'($urandom_range(0, 9));
      if (mode == 0) setBank(8'($urandom));
      else access(8'($urandom), mode[0], mode < 4, 12'($urandom), mode[1], 8'($urandom), "R5 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule